// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block keeps a small fully associative set of recent address translations. Each slot pairs a lookup key with the page table entry that the translation produces. The key is a 2-bit region code followed by a 21-bit virtual page number. Because every slot also records the identifier of the process that installed it, two processes may each hold a slot for the same page (for example page 0 of the same region) with different mappings. A lookup never returns a mapping that belongs to another process. Slots in the system region are shared by all processes: they match any process identifier.

Lookups are purely combinational. A fill installs or updates a slot at the next clock edge. New keys are placed round-robin, and a fill whose key is already present rewrites that slot in place. A mode input selects how context switches are handled. In tagged mode the switch strobe has no effect and the process tags keep mappings apart. In wipe mode the strobe discards every non-system slot, so the next lookup starts from an empty private set. A separate flush input empties the whole buffer, system slots included, in one edge.

Control works through one decoded command per cycle, taken from an enumeration. CMD_WIPE_ALL is chosen when flush is high. CMD_PURGE is chosen when the switch strobe is high in wipe mode. CMD_FILL is chosen when fill is high. CMD_IDLE is chosen otherwise. Where several of these hold in the same cycle, they are chosen in that order of priority. Within CMD_FILL there are two cases: an in-place update when the fill key already matches a slot, and an allocation at the round-robin pointer when it does not.

Top module: `proc_tlb`

## Requirements
- R1: After reset every slot is empty: every lookup misses, lk_pte reads 0, and the round-robin pointer is at slot 0.
- R2: A lookup is answered in the same cycle it is presented. On a hit, lk_hit=1 and lk_pte is the stored entry. On a miss, lk_hit=0 and lk_pte=0.
- R3: The key compares region (2 bits) and page number (21 bits). Region 2'b00 and region 2'b01 with the same page number are distinct slots.
- R4: A slot whose region is not 2'b10 hits only when its stored process identifier equals cur_pid. Two processes can hold the same key at once with different entries.
- R5: A slot filled with region 2'b10 is global: it hits for every value of cur_pid.
- R6: A fill takes effect at the next clock edge and records cur_pid. A fill whose key matches a slot under the R4/R5 rules overwrites that slot and leaves the pointer unchanged.
- R7: A fill that allocates writes the slot at the pointer, and the pointer then steps by one modulo 8. With 8 slots, the ninth distinct key evicts the first.
- R8: When wipe_mode=1, ctx_sw drops every non-global slot at that edge, and global slots remain. When wipe_mode=0, ctx_sw has no effect.
- R9: flush empties all slots, global ones included, in one edge.
- R10: Priority is flush, then wipe-mode ctx_sw, then fill. A fill in the same cycle as either of the others is discarded and does not move the pointer.
- R11: No key and process identifier ever matches more than one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wipe_mode | input | 1 | 1: context switch discards private slots; 0: tagged mode |
| cur_pid | input | 6 | Identifier of the running process |
| ctx_sw | input | 1 | Context-switch strobe |
| flush | input | 1 | Empty the whole buffer |
| lk_region | input | 2 | Lookup region code |
| lk_vpn | input | 21 | Lookup virtual page number |
| lk_hit | output | 1 | Lookup hit |
| lk_pte | output | 32 | Entry on hit, 0 on miss |
| fill_en | input | 1 | Install a translation |
| fill_region | input | 2 | Fill region code |
| fill_vpn | input | 21 | Fill virtual page number |
| fill_pte | input | 32 | Entry to store |

## Verification
Lookup results are due in the same cycle as the key, with zero register delay. Fills, context switches and flushes change what lookups return only from the cycle after their edge. The bench therefore drives inputs just after the falling edge and compares lk_hit and lk_pte a quarter period later, before the rising edge. It then applies that cycle's fill, switch or flush to its behavioural model at the rising edge. A slot written in cycle t is consequently first expected to hit in cycle t+1, and a purge or flush in cycle t is first expected to produce misses in cycle t+1.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam logic [1:0] RGN_SYS = 2'b10;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_FILL,
        CMD_PURGE,
        CMD_WIPE_ALL
    } tlb_cmd_e;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
(
    input  logic flush,
    input  logic ctx_sw,
    input  logic wipe_mode,
    input  logic fill_en,
    input  logic fill_hit,
    output logic clr_all,
    output logic clr_local,
    output logic do_alloc,
    output logic do_update
);
    tlb_cmd_e cmd;

    always_comb begin
        if (flush)                       cmd = CMD_WIPE_ALL;
        else if (ctx_sw && wipe_mode)    cmd = CMD_PURGE;
        else if (fill_en)                cmd = CMD_FILL;
        else                             cmd = CMD_IDLE;
    end

    always_comb begin
        clr_all   = 1'b0;
        clr_local = 1'b0;
        do_alloc  = 1'b0;
        do_update = 1'b0;
        unique case (cmd)
            CMD_WIPE_ALL: clr_all   = 1'b1;
            CMD_PURGE:    clr_local = 1'b1;
            CMD_FILL: begin
                do_update = fill_hit;
                do_alloc  = !fill_hit;
            end
            CMD_IDLE: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/tlb_rr.sv
module tlb_rr #(
    parameter int N = 8,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [PW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (step)
            ptr <= (ptr == PW'(N - 1)) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/tlb_slot.sv
module tlb_slot #(
    parameter int KEY_W = 23,
    parameter int PID_W = 6,
    parameter int PTE_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             clr_local,
    input  logic             wr,
    input  logic [KEY_W-1:0] wr_key,
    input  logic             wr_glob,
    input  logic [PTE_W-1:0] wr_pte,
    input  logic [PID_W-1:0] cur_pid,
    input  logic [KEY_W-1:0] lk_key,
    input  logic [KEY_W-1:0] fl_key,
    output logic             lk_match,
    output logic             fl_match,
    output logic [PTE_W-1:0] pte
);
    logic             vld;
    logic             glob;
    logic [KEY_W-1:0] key;
    logic [PID_W-1:0] pid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            glob <= 1'b0;
            key  <= '0;
            pid  <= '0;
            pte  <= '0;
        end else if (clr_all) begin
            vld <= 1'b0;
        end else if (clr_local && !glob) begin
            vld <= 1'b0;
        end else if (wr) begin
            vld  <= 1'b1;
            glob <= wr_glob;
            key  <= wr_key;
            pid  <= cur_pid;
            pte  <= wr_pte;
        end
    end

    logic owner_ok;
    assign owner_ok = glob || (pid == cur_pid);
    assign lk_match = vld && owner_ok && (key == lk_key);
    assign fl_match = vld && owner_ok && (key == fl_key);
endmodule

// File: rtl/proc_tlb.sv
module proc_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 21,
    parameter int PID_W   = 6,
    parameter int PTE_W   = 32,
    localparam int RGN_W  = 2,
    localparam int KEY_W  = RGN_W + VPN_W,
    localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wipe_mode,
    input  logic [PID_W-1:0] cur_pid,
    input  logic             ctx_sw,
    input  logic             flush,
    input  logic [RGN_W-1:0] lk_region,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PTE_W-1:0] lk_pte,
    input  logic             fill_en,
    input  logic [RGN_W-1:0] fill_region,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PTE_W-1:0] fill_pte
);
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fl_match;
    logic [PTE_W-1:0]   slot_pte [ENTRIES];
    logic [PTR_W-1:0]   rr_ptr;
    logic               clr_all, clr_local, do_alloc, do_update;
    logic [KEY_W-1:0]   lk_key, fl_key;

    assign lk_key = {lk_region, lk_vpn};
    assign fl_key = {fill_region, fill_vpn};

    tlb_ctrl u_ctrl (
        .flush     (flush),
        .ctx_sw    (ctx_sw),
        .wipe_mode (wipe_mode),
        .fill_en   (fill_en),
        .fill_hit  (|fl_match),
        .clr_all   (clr_all),
        .clr_local (clr_local),
        .do_alloc  (do_alloc),
        .do_update (do_update)
    );

    tlb_rr #(.N(ENTRIES)) u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (do_alloc),
        .ptr   (rr_ptr)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic wr;
        assign wr = (do_alloc && (rr_ptr == PTR_W'(g))) || (do_update && fl_match[g]);
        tlb_slot #(.KEY_W(KEY_W), .PID_W(PID_W), .PTE_W(PTE_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_all   (clr_all),
            .clr_local (clr_local),
            .wr        (wr),
            .wr_key    (fl_key),
            .wr_glob   (fill_region == RGN_SYS),
            .wr_pte    (fill_pte),
            .cur_pid   (cur_pid),
            .lk_key    (lk_key),
            .fl_key    (fl_key),
            .lk_match  (lk_match[g]),
            .fl_match  (fl_match[g]),
            .pte       (slot_pte[g])
        );
    end

    always_comb begin
        lk_pte = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (lk_match[i]) lk_pte = lk_pte | slot_pte[i];
    end
    assign lk_hit = |lk_match;
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
    parameter int N     = 8,
    parameter int PTE_W = 32,
    localparam int PW   = (N > 1) ? $clog2(N) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             ctx_sw,
    input logic             wipe_mode,
    input logic [1:0]       lk_region,
    input logic             lk_hit,
    input logic [PTE_W-1:0] lk_pte,
    input logic [N-1:0]     lk_vec,
    input logic [PW-1:0]    rr_ptr,
    input logic             alloc
);
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec)); // R11
    AST_MISS_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pte == '0)); // R2
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit); // R9
    AST_PURGE_KEEPS_SYS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_sw && wipe_mode && !flush) |=> (!lk_hit || lk_region == 2'b10)); // R8
    AST_RR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> (rr_ptr == (($past(rr_ptr) == PW'(N - 1)) ? '0 : $past(rr_ptr) + 1'b1))); // R7
    AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc |=> $stable(rr_ptr)); // R7
    AST_NO_ALLOC_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flush || (ctx_sw && wipe_mode)) |-> !alloc); // R10
endmodule

bind proc_tlb tlb_chk #(.N(ENTRIES), .PTE_W(PTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .ctx_sw    (ctx_sw),
    .wipe_mode (wipe_mode),
    .lk_region (lk_region),
    .lk_hit    (lk_hit),
    .lk_pte    (lk_pte),
    .lk_vec    (lk_match),
    .rr_ptr    (rr_ptr),
    .alloc     (do_alloc)
);

// File: tb/proc_tlb_tb.sv
module proc_tlb_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wipe_mode = 1'b0;
    logic [5:0]  cur_pid = '0;
    logic        ctx_sw = 1'b0;
    logic        flush = 1'b0;
    logic [1:0]  lk_region = '0;
    logic [20:0] lk_vpn = '0;
    logic        lk_hit;
    logic [31:0] lk_pte;
    logic        fill_en = 1'b0;
    logic [1:0]  fill_region = '0;
    logic [20:0] fill_vpn = '0;
    logic [31:0] fill_pte = '0;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    logic        m_v [8];
    logic        m_g [8];
    logic [22:0] m_k [8];
    logic [5:0]  m_p [8];
    logic [31:0] m_e [8];
    int          m_ptr = 0;

    always #10 clk = ~clk;

    proc_tlb u_dut (
        .clk(clk), .rst_n(rst_n), .wipe_mode(wipe_mode), .cur_pid(cur_pid),
        .ctx_sw(ctx_sw), .flush(flush), .lk_region(lk_region), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_pte(lk_pte), .fill_en(fill_en),
        .fill_region(fill_region), .fill_vpn(fill_vpn), .fill_pte(fill_pte)
    );

    function automatic int m_find(input logic [22:0] k);
        for (int i = 0; i < 8; i++)
            if (m_v[i] && m_k[i] == k && (m_g[i] || m_p[i] == cur_pid)) return i;
        return -1;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 8; i++) begin
            m_v[i] = 1'b0; m_g[i] = 1'b0; m_k[i] = '0; m_p[i] = '0; m_e[i] = '0;
        end
        m_ptr = 0;
    endtask

    task automatic m_edge();
        if (!rst_n) m_reset();
        else if (flush) begin
            for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
        end else if (ctx_sw && wipe_mode) begin
            for (int i = 0; i < 8; i++) if (!m_g[i]) m_v[i] = 1'b0;
        end else if (fill_en) begin
            int idx;
            idx = m_find({fill_region, fill_vpn});
            if (idx < 0) begin
                idx = m_ptr;
                m_ptr = (m_ptr + 1) % 8;
            end
            m_v[idx] = 1'b1;
            m_g[idx] = (fill_region == 2'b10);
            m_k[idx] = {fill_region, fill_vpn};
            m_p[idx] = cur_pid;
            m_e[idx] = fill_pte;
        end
    endtask

    // drive after negedge; compare at +5; model updates at posedge
    task automatic cycle();
        int    idx;
        bit    eh;
        logic [31:0] ep;
        #5;
        if (!done) begin
            idx = m_find({lk_region, lk_vpn});
            eh  = (idx >= 0) && rst_n;
            ep  = eh ? m_e[idx] : 32'h0;
            n_vec++;
            if (lk_hit !== eh || lk_pte !== ep) begin
                n_bad++;
                $display("FAIL %s: key=%b/%h pid=%0d hit=%0b pte=%h expected hit=%0b pte=%h",
                         cur_req, lk_region, lk_vpn, cur_pid, lk_hit, lk_pte, eh, ep);
            end
        end
        @(posedge clk);
        m_edge();
        @(negedge clk);
        fill_en = 1'b0; ctx_sw = 1'b0; flush = 1'b0;
    endtask

    task automatic probe(input logic [1:0] r, input logic [20:0] v, input logic [5:0] p);
        lk_region = r; lk_vpn = v; cur_pid = p;
        cycle();
    endtask

    task automatic fill(input logic [1:0] r, input logic [20:0] v, input logic [5:0] p,
                        input logic [31:0] e);
        fill_en = 1'b1; fill_region = r; fill_vpn = v; fill_pte = e; cur_pid = p;
        lk_region = r; lk_vpn = v;
        cycle();
    endtask

    initial begin
        m_reset();
        @(negedge clk);
        cur_req = "R1";
        probe(2'b00, 21'd0, 6'd0);
        probe(2'b10, 21'd3, 6'd1);
        rst_n = 1'b1;
        probe(2'b00, 21'd0, 6'd0);

        cur_req = "R3";
        fill(2'b00, 21'd5, 6'd1, 32'hA000_0001);
        fill(2'b01, 21'd5, 6'd1, 32'hB000_0002);
        probe(2'b00, 21'd5, 6'd1);
        probe(2'b01, 21'd5, 6'd1);
        probe(2'b11, 21'd5, 6'd1);

        cur_req = "R4";
        fill(2'b00, 21'd5, 6'd2, 32'hC000_0003);
        probe(2'b00, 21'd5, 6'd1);
        probe(2'b00, 21'd5, 6'd2);
        probe(2'b00, 21'd5, 6'd3);

        cur_req = "R5";
        fill(2'b10, 21'd7, 6'd1, 32'hD000_0004);
        probe(2'b10, 21'd7, 6'd9);
        probe(2'b10, 21'd7, 6'd63);

        cur_req = "R6";
        fill(2'b00, 21'd5, 6'd1, 32'hE000_0005);
        probe(2'b00, 21'd5, 6'd1);
        probe(2'b00, 21'd5, 6'd2);
        fill(2'b10, 21'd7, 6'd4, 32'hF000_0006);
        probe(2'b10, 21'd7, 6'd1);

        cur_req = "R8";
        wipe_mode = 1'b0; ctx_sw = 1'b1;
        probe(2'b00, 21'd5, 6'd1);
        probe(2'b00, 21'd5, 6'd2);
        wipe_mode = 1'b1; ctx_sw = 1'b1;
        probe(2'b00, 21'd5, 6'd2);
        probe(2'b00, 21'd5, 6'd2);
        probe(2'b10, 21'd7, 6'd2);
        wipe_mode = 1'b0;

        cur_req = "R9";
        flush = 1'b1;
        probe(2'b10, 21'd7, 6'd2);
        probe(2'b10, 21'd7, 6'd2);

        cur_req = "R7";
        for (int i = 0; i < 9; i++) fill(2'b00, 21'(100 + i), 6'd1, 32'h1000 + i);
        probe(2'b00, 21'd100, 6'd1);
        probe(2'b00, 21'd101, 6'd1);
        probe(2'b00, 21'd108, 6'd1);
        fill(2'b00, 21'd102, 6'd1, 32'h2222);
        for (int i = 0; i < 6; i++) fill(2'b01, 21'(200 + i), 6'd1, 32'h3000 + i);
        probe(2'b00, 21'd102, 6'd1);
        probe(2'b00, 21'd103, 6'd1);

        cur_req = "R10";
        flush = 1'b1; fill(2'b00, 21'd9, 6'd1, 32'h9999);
        probe(2'b00, 21'd9, 6'd1);
        fill(2'b10, 21'd1, 6'd1, 32'h1111);
        wipe_mode = 1'b1; ctx_sw = 1'b1; fill(2'b00, 21'd9, 6'd1, 32'h9999);
        probe(2'b00, 21'd9, 6'd1);
        probe(2'b10, 21'd1, 6'd5);
        wipe_mode = 1'b0;

        cur_req = "R11/R2";
        for (int i = 0; i < 400; i++) begin
            fill_en     = ($urandom_range(0, 2) != 0);
            fill_region = 2'($urandom_range(0, 3));
            fill_vpn    = 21'($urandom_range(0, 5));
            fill_pte    = $urandom;
            flush       = ($urandom_range(0, 40) == 0);
            ctx_sw      = ($urandom_range(0, 15) == 0);
            wipe_mode   = ($urandom_range(0, 1) == 1);
            probe(2'($urandom_range(0, 3)), 21'($urandom_range(0, 5)),
                  6'($urandom_range(0, 2)));
        end

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule